// File: doc/BRIEF.md
# SPI serial flash command engine

This block is a synthesizable behavioural model of a small serial NOR flash that sits on an SPI bus. It oversamples the serial clock, chip select and data-in lines with the system clock and accepts either clock polarity (mode 0 or mode 3). The first byte of each selected transfer is the command. Some commands then take a 24-bit address, most significant byte first. Data goes out on MISO, most significant bit first, updated on falling serial clock edges. MISO is driven only while chip select is low.

The storage is a parameterised byte array, organised as sectors that are made of pages. Writes follow NOR rules. Programming can only turn ones into zeros. Erasing restores a whole sector, or the whole array, to FFh. Program, erase and status-write cycles are timed by a cycle counter. While a cycle runs, the block answers only status reads. Write-type commands take effect only when chip select rises after a whole number of bytes, and only if the write-enable latch was set beforehand. Checking of the protected area belongs to a neighbouring block. This block only stores the protection field.

Top module: `sflash_engine`

## Requirements
- R1: After reset, MISO is not driven, the status byte reads 00h and every array byte reads FFh.
- R2: Input bits are taken on rising SCK edges and output bits are launched on falling SCK edges, MSB first, with SCK idling either low (mode 0) or high (mode 3). `spi_miso_oe` is 0 whenever chip select is high.
- R3: Status layout: bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 4:2 and bit 7 are the stored protection bits, and the other bits read 0. Opcode 06h sets the latch, 04h clears it, and 05h streams the status byte.
- R4: Opcode 9Fh returns the three identification bytes 20h, 20h, 13h.
- R5: Program (02h), sector erase (D8h), bulk erase (C7h) and status write (01h) have no effect unless the write-enable latch is set.
- R6: Program stores old AND new in each addressed byte. Data bytes that run past the end of a page continue at the start of the same page.
- R7: Sector erase sets every byte of the sector that holds the address to FFh and leaves other sectors unchanged. Bulk erase sets every byte to FFh.
- R8: Read (03h) starts at any address and increments after each byte. It wraps from the top address to 0. Fast read (0Bh) behaves the same after one dummy byte.
- R9: A write-type command runs only if chip select rises after a multiple of 8 SCK bits. Otherwise nothing changes, and that includes the write-enable latch.
- R10: While a program, erase or status-write cycle runs, status bit 0 reads 1 and every opcode other than 05h is ignored. The latch clears when the cycle ends.
- R11: After B9h (deep power-down), every opcode except ABh is ignored. ABh followed by three dummy bytes returns 12h and leaves deep power-down.
- R12: Status write (01h) updates only bits 7 and 4:2 of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High while MISO should be driven |

## Verification
The bench builds the block with 8 sectors of 32 bytes and 16-byte pages, which gives a 256-byte array. With this array, wrap at the top address, wrap inside a page and sector boundaries can all be reached in a few bytes of traffic. Program and erase times are set to 800 and 1000 system cycles. These are short enough to poll the status byte until the cycle ends. They are also long enough for a status read and a rejected program command to arrive while the cycle is still running.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDID = 8'h9F;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    typedef enum logic [2:0] {
        ST_OP, ST_ADDR, ST_DUMMY, ST_DATA, ST_OUT, ST_WAIT, ST_IGN
    } sfe_state_e;

    typedef enum logic [1:0] {
        SRC_MEM, SRC_SR, SRC_ID, SRC_SIG
    } sfe_src_e;
endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_rise,
    output logic mosi_s
);
    typedef struct packed {
        logic [2:0] sck;
        logic [2:0] csn;
        logic [1:0] mosi;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.sck  = {q.sck[1:0], sck_i};
        d.csn  = {q.csn[1:0], csn_i};
        d.mosi = {q.mosi[0], mosi_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sck: 3'b000, csn: 3'b111, mosi: 2'b00};
        else        q <= d;
    end

    assign cs_act   = ~q.csn[1];
    assign cs_rise  = q.csn[1] & ~q.csn[2];
    assign sck_rise = cs_act & q.sck[1] & ~q.sck[2];
    assign sck_fall = cs_act & ~q.sck[1] & q.sck[2];
    assign mosi_s   = q.mosi[1];
endmodule

// File: rtl/sfe_array.sv
module sfe_array #(
    parameter int SECTORS      = 8,
    parameter int SECTOR_BYTES = 256,
    parameter int PAGE_BYTES   = 256,
    localparam int TOTAL = SECTORS * SECTOR_BYTES,
    localparam int AW    = $clog2(TOTAL),
    localparam int CW    = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          buf_clr,
    input  logic          buf_we,
    input  logic [CW-1:0] buf_col,
    input  logic [7:0]    buf_din,
    input  logic          prog_go,
    input  logic          erase_go,
    input  logic          erase_all,
    input  logic [AW-1:0] op_addr
);
    localparam int SW = $clog2(SECTOR_BYTES);
    localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_BYTES - 1);

    logic [7:0] mem  [TOTAL];
    logic [7:0] pbuf [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
            for (int p = 0; p < PAGE_BYTES; p++) pbuf[p] <= 8'hFF;
        end else begin
            if (buf_clr) begin
                for (int p = 0; p < PAGE_BYTES; p++) pbuf[p] <= 8'hFF;
            end else if (buf_we) begin
                pbuf[buf_col] <= buf_din;
            end
            if (prog_go) begin
                for (int p = 0; p < PAGE_BYTES; p++)
                    mem[(op_addr & PAGE_MASK) | AW'(p)] <= mem[(op_addr & PAGE_MASK) | AW'(p)] & pbuf[p];
            end
            if (erase_go) begin
                for (int i = 0; i < TOTAL; i++)
                    if (erase_all || ((AW'(i) >> SW) == (op_addr >> SW))) mem[i] <= 8'hFF;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: a program cycle never turns a 0 bit into a 1
    p_prog_only_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prog_go) && $stable(rd_addr)) |-> ((rd_data & ~$past(rd_data)) == 8'h00));

    // R7: after a bulk erase every location reads FFh
    p_bulk_erase_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase_go && erase_all) |-> (rd_data == 8'hFF));
endmodule

// File: rtl/sflash_engine.sv
module sflash_engine
    import sfe_pkg::*;
#(
    parameter int         SECTORS      = 8,
    parameter int         SECTOR_BYTES = 256,
    parameter int         PAGE_BYTES   = 256,
    parameter int         T_PROG       = 1000,
    parameter int         T_ERASE      = 5000,
    parameter logic [7:0] ID_MFR       = 8'h20,
    parameter logic [7:0] ID_TYPE      = 8'h20,
    parameter logic [7:0] ID_CAP       = 8'h13,
    parameter logic [7:0] SIGNATURE    = 8'h12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int TOTAL = SECTORS * SECTOR_BYTES;
    localparam int AW    = $clog2(TOTAL);
    localparam int CW    = $clog2(PAGE_BYTES);
    localparam int TMAX  = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
    localparam int TW    = $clog2(TMAX + 1);

    typedef struct packed {
        sfe_state_e    st;
        logic [7:0]    op;
        logic [2:0]    bcnt;
        logic [1:0]    acnt;
        logic [AW-1:0] addr;
        logic [6:0]    sh;
        logic [2:0]    obit;
        sfe_src_e      src;
        logic [1:0]    idx;
        logic          wel;
        logic [3:0]    prot;
        logic [3:0]    wrv;
        logic          dpd;
        logic          miso;
        logic          pp_any;
        logic [TW-1:0] busy;
    } eng_t;

    eng_t q, d;

    logic sck_rise, sck_fall, cs_act, cs_rise, mosi_s;
    logic buf_clr, buf_we, prog_go, erase_go, erase_all;
    logic [7:0] rd_data, byte_w, sr_byte, cur_byte;
    logic wip;

    sfe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .csn_i(spi_csn), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .cs_rise(cs_rise),
        .mosi_s(mosi_s)
    );

    sfe_array #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(q.addr), .rd_data(rd_data),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_col(q.addr[CW-1:0]), .buf_din(byte_w),
        .prog_go(prog_go), .erase_go(erase_go), .erase_all(erase_all), .op_addr(q.addr)
    );

    assign wip     = (q.busy != '0);
    assign byte_w  = {q.sh, mosi_s};
    assign sr_byte = {q.prot[3], 2'b00, q.prot[2:0], q.wel, wip};

    always_comb begin
        unique case (q.src)
            SRC_MEM: cur_byte = rd_data;
            SRC_SR:  cur_byte = sr_byte;
            SRC_ID:  cur_byte = (q.idx == 2'd0) ? ID_MFR : (q.idx == 2'd1) ? ID_TYPE : ID_CAP;
            default: cur_byte = SIGNATURE;
        endcase
    end

    always_comb begin
        d = q;
        buf_clr = 1'b0; buf_we = 1'b0;
        prog_go = 1'b0; erase_go = 1'b0; erase_all = 1'b0;

        if (wip) begin
            d.busy = q.busy - 1'b1;
            if (q.busy == TW'(1)) d.wel = 1'b0;
        end

        if (sck_rise) begin
            d.sh   = byte_w[6:0];
            d.bcnt = q.bcnt + 3'd1;
            if (q.bcnt == 3'd7) begin
                case (q.st)
                    ST_OP: begin
                        d.op = byte_w; d.acnt = '0; d.obit = '0; d.idx = '0;
                        if ((q.dpd && byte_w != OP_RES) || (wip && byte_w != OP_RDSR)) d.st = ST_IGN;
                        else begin
                            case (byte_w)
                                OP_WREN, OP_WRDI, OP_BE, OP_DP: d.st = ST_WAIT;
                                OP_RDSR: begin d.st = ST_OUT; d.src = SRC_SR; end
                                OP_RDID: begin d.st = ST_OUT; d.src = SRC_ID; end
                                OP_READ, OP_FAST, OP_SE, OP_RES: d.st = ST_ADDR;
                                OP_PP:   begin d.st = ST_ADDR; buf_clr = 1'b1; d.pp_any = 1'b0; end
                                OP_WRSR: d.st = ST_DATA;
                                default: d.st = ST_IGN;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        d.addr = AW'({q.addr, byte_w});
                        d.acnt = q.acnt + 2'd1;
                        d.obit = '0;
                        if (q.acnt == 2'd2) begin
                            case (q.op)
                                OP_READ: begin d.st = ST_OUT; d.src = SRC_MEM; end
                                OP_FAST: d.st = ST_DUMMY;
                                OP_PP:   d.st = ST_DATA;
                                OP_SE:   d.st = ST_WAIT;
                                default: begin d.st = ST_OUT; d.src = SRC_SIG; end
                            endcase
                        end
                    end
                    ST_DUMMY: begin d.st = ST_OUT; d.src = SRC_MEM; d.obit = '0; end
                    ST_DATA: begin
                        if (q.op == OP_PP) begin
                            buf_we   = 1'b1;
                            d.pp_any = 1'b1;
                            d.addr   = {q.addr[AW-1:CW], CW'(q.addr[CW-1:0] + 1'b1)};
                        end else begin
                            d.wrv = {byte_w[7], byte_w[4:2]};
                            d.st  = ST_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (sck_fall && q.st == ST_OUT) begin
            d.miso = cur_byte[3'd7 - q.obit];
            d.obit = q.obit + 3'd1;
            if (q.obit == 3'd7) begin
                if (q.src == SRC_MEM) d.addr = q.addr + 1'b1;
                if (q.src == SRC_ID && q.idx != 2'd2) d.idx = q.idx + 2'd1;
            end
        end

        if (cs_rise) begin
            if (q.op == OP_RES && q.st != ST_OP && q.st != ST_IGN) d.dpd = 1'b0;
            if (q.bcnt == 3'd0) begin
                if (q.st == ST_WAIT) begin
                    case (q.op)
                        OP_WREN: d.wel = 1'b1;
                        OP_WRDI: d.wel = 1'b0;
                        OP_DP:   d.dpd = 1'b1;
                        OP_BE:   if (q.wel) begin erase_go = 1'b1; erase_all = 1'b1; d.busy = TW'(T_ERASE); end
                        OP_SE:   if (q.wel) begin erase_go = 1'b1; d.busy = TW'(T_ERASE); end
                        OP_WRSR: if (q.wel) begin d.prot = q.wrv; d.busy = TW'(T_PROG); end
                        default: ;
                    endcase
                end else if (q.st == ST_DATA && q.op == OP_PP && q.pp_any && q.wel) begin
                    prog_go = 1'b1;
                    d.busy  = TW'(T_PROG);
                end
            end
            d.st = ST_OP; d.bcnt = '0; d.acnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso    = q.miso;
    assign spi_miso_oe = cs_act;

    // R10: no new array cycle starts while one is running
    p_busy_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !(prog_go || erase_go));
    // R10: the latch is clear on the cycle the busy counter expires
    p_wel_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy == '0 && $past(q.busy) == TW'(1)) |-> !q.wel);
    // R5: array writes need the write-enable latch
    p_write_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> q.wel);
    // R9: a partial byte at chip-select rise starts nothing
    p_partial_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && q.bcnt != 3'd0) |-> !(prog_go || erase_go));
    // R11: in deep power-down only the release opcode advances
    p_dpd_only_res_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dpd && q.st != ST_OP && q.st != ST_IGN) |-> (q.op == OP_RES));
endmodule

// File: tb/sflash_engine_tb.sv
module sflash_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic idle_hi = 1'b0;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_engine #(
        .SECTORS(8), .SECTOR_BYTES(32), .PAGE_BYTES(16), .T_PROG(800), .T_ERASE(1000)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    // {address, program data, expected byte after program}: R6
    localparam logic [23:0] VEC [6] = '{
        24'h05F0F0, 24'h053C30, 24'h05FF30, 24'h105A5A, 24'hFFA5A5, 24'h008181
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", what, act, exp);
        end
    endtask

    task automatic set_mode(input int m);
        idle_hi = (m == 3);
        sck = idle_hi;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            sck = 1'b0; mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso; sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic cs_lo();
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        sck = idle_hi;
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xb(op, r); cs_hi();
    endtask

    task automatic send_addr(input logic [7:0] a);
        logic [7:0] r;
        xb(8'h00, r); xb(8'h00, r); xb(a, r);
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); xb(8'h05, r); xb(8'h00, s); cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 50; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xb(8'h03, r); send_addr(a); xb(8'h00, v); cs_hi();
    endtask

    task automatic prog1(input logic [7:0] a, input logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xb(8'h02, r); send_addr(a); xb(v, r); cs_hi();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r, s, v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R2: reset state, output not driven while deselected
        chk({7'b0, miso_oe}, 8'h00, "R1 R2 miso_oe at reset");
        rdsr(s);        chk(s, 8'h00, "R1 status after reset");
        read_at(8'h00, v); chk(v, 8'hFF, "R1 array after reset");
        read_at(8'hC7, v); chk(v, 8'hFF, "R1 array after reset high");

        // R4 in mode 0 and mode 3 (R2)
        for (int m = 0; m <= 3; m += 3) begin
            set_mode(m);
            cs_lo(); xb(8'h9F, r);
            xb(8'h00, v); chk(v, 8'h20, "R4 R2 id byte0");
            xb(8'h00, v); chk(v, 8'h20, "R4 R2 id byte1");
            xb(8'h00, v); chk(v, 8'h13, "R4 R2 id byte2");
            cs_hi();
        end
        set_mode(0);

        // R3: latch set and clear
        cmd1(8'h06); rdsr(s); chk(s, 8'h02, "R3 WEL after 06h");
        cmd1(8'h04); rdsr(s); chk(s, 8'h00, "R3 WEL after 04h");

        // R5: writes without the latch
        prog1(8'h70, 8'h00); read_at(8'h70, v); chk(v, 8'hFF, "R5 program without WEL");
        cs_lo(); xb(8'h01, r); xb(8'hFF, r); cs_hi();
        rdsr(s); chk(s, 8'h00, "R5 status write without WEL");

        // R6: table walk, alternating modes
        for (int i = 0; i < 6; i++) begin
            set_mode((i % 2) ? 3 : 0);
            cmd1(8'h06);
            prog1(VEC[i][23:16], VEC[i][15:8]);
            wait_idle();
            read_at(VEC[i][23:16], v);
            chk(v, VEC[i][7:0], "R6 program AND table");
        end
        set_mode(0);

        // R10: busy window
        cmd1(8'h06);
        prog1(8'h50, 8'h77);
        rdsr(s); chk(s, 8'h03, "R10 WIP and WEL during cycle");
        prog1(8'h60, 8'h00);
        wait_idle();
        rdsr(s); chk(s, 8'h00, "R10 WEL cleared after cycle");
        read_at(8'h50, v); chk(v, 8'h77, "R6 programmed byte");
        read_at(8'h60, v); chk(v, 8'hFF, "R10 program during busy ignored");

        // R6: page wrap, page at 20h with 16-byte pages
        cmd1(8'h06);
        cs_lo(); xb(8'h02, r); send_addr(8'h2E);
        xb(8'h11, r); xb(8'h22, r); xb(8'h33, r); xb(8'h44, r); cs_hi();
        wait_idle();
        read_at(8'h2E, v); chk(v, 8'h11, "R6 wrap 2Eh");
        read_at(8'h2F, v); chk(v, 8'h22, "R6 wrap 2Fh");
        read_at(8'h20, v); chk(v, 8'h33, "R6 wrap 20h");
        read_at(8'h21, v); chk(v, 8'h44, "R6 wrap 21h");
        read_at(8'h30, v); chk(v, 8'hFF, "R6 next page untouched");

        // R9: partial byte before chip-select rise
        cmd1(8'h06);
        cs_lo(); xb(8'h02, r); send_addr(8'h30); xb(8'h00, r); spi_bits(8'h00, 3, r); cs_hi();
        read_at(8'h30, v); chk(v, 8'hFF, "R9 aborted program");
        rdsr(s); chk(s, 8'h02, "R9 latch kept after abort");
        cmd1(8'h04);

        // R8: read wrap and fast read
        cs_lo(); xb(8'h03, r); send_addr(8'hFE);
        xb(8'h00, v); chk(v, 8'hFF, "R8 read FEh");
        xb(8'h00, v); chk(v, 8'hA5, "R8 read FFh");
        xb(8'h00, v); chk(v, 8'h81, "R8 wrap to 00h");
        cs_hi();
        set_mode(3);
        cs_lo(); xb(8'h0B, r); send_addr(8'hFF); xb(8'h00, r);
        xb(8'h00, v); chk(v, 8'hA5, "R8 fast read FFh");
        xb(8'h00, v); chk(v, 8'h81, "R8 fast read wrap");
        cs_hi();
        set_mode(0);

        // R7: sector erase of sector 20h..3Fh
        cmd1(8'h06);
        cs_lo(); xb(8'hD8, r); send_addr(8'h25); cs_hi();
        wait_idle();
        read_at(8'h20, v); chk(v, 8'hFF, "R7 sector erased 20h");
        read_at(8'h2F, v); chk(v, 8'hFF, "R7 sector erased 2Fh");
        read_at(8'h10, v); chk(v, 8'h5A, "R7 other sector kept");
        read_at(8'h50, v); chk(v, 8'h77, "R7 next sector kept");

        // R12: status write field
        cmd1(8'h06);
        cs_lo(); xb(8'h01, r); xb(8'hFF, r); cs_hi();
        wait_idle();
        rdsr(s); chk(s, 8'h9C, "R12 writable status bits");
        cmd1(8'h06);
        cs_lo(); xb(8'h01, r); xb(8'h00, r); cs_hi();
        wait_idle();
        rdsr(s); chk(s, 8'h00, "R12 status cleared");

        // R11: deep power-down
        cmd1(8'hB9);
        cmd1(8'h06);
        cs_lo(); xb(8'hAB, r); send_addr(8'h00); xb(8'h00, v); cs_hi();
        chk(v, 8'h12, "R11 release signature");
        rdsr(s); chk(s, 8'h00, "R11 opcode ignored in power-down");

        // R7: bulk erase
        cmd1(8'h06); cmd1(8'hC7);
        wait_idle();
        read_at(8'h10, v); chk(v, 8'hFF, "R7 bulk erase 10h");
        read_at(8'h50, v); chk(v, 8'hFF, "R7 bulk erase 50h");
        chk({7'b0, miso_oe}, 8'h00, "R2 miso_oe deselected");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule